// File: doc/BRIEF.md
# Repeating Status Byte Readout

This block handles the status-read command of a serial flash model. While chip select is low, it collects a command byte from the serial input, sampled on rising SCK edges. When that byte is 0x57, it drives an 8-bit status byte on the serial output, most significant bit first, with one bit per SCK cycle. The byte repeats for as long as chip select stays low and SCK keeps toggling. The status fields are sampled again at the start of each repetition. Bit 7 follows the sequencer's busy line directly, so a host can stop SCK once bit 7 is showing and watch the output rise when the operation completes.

The SCK and chip-select pins are sampled on the model's own clock, which runs well above the SCK rate. A dedicated detector turns SCK into rise and fall pulses. An opcode shifter collects the command byte. A serializer holds the status frame and the bit index. A state machine sequences the read with these states:
- ST_IDLE: chip select is high.
- ST_OPCODE: the command byte is being collected.
- ST_ARMED: the opcode matched, and the block waits for the falling edge that presents bit 7.
- ST_STREAM: the status byte is being driven.
- ST_IGNORE: the opcode was some other command.

The transitions are:
- IDLE→OPCODE when chip select falls.
- OPCODE→ARMED on the eighth rise if the byte is 0x57.
- OPCODE→IGNORE on the eighth rise for any other byte.
- ARMED→STREAM on the next SCK fall.
- Any state→IDLE when chip select rises.

Top module: `status_readout`

## Requirements
- R1: While chip select is high, and after reset, the output enable `so_oe` is 0 and `so_data` is 0, which stands for high impedance.
- R2: Command bits are taken MSB first on rising SCK edges. Only a complete 8-bit command equal to 0x57 starts the readout. Bit 7 of the status is driven from the SCK falling edge that ends the eighth command cycle.
- R3: The status layout is as follows. Bit 7 is ready, equal to the inverse of `busy`. Bit 6 is the compare result. Bits 5:3 are the density code. Bits 2:0 are reserved and driven as 0.
- R4: After bit 0 has been driven, the next SCK falling edge drives bit 7 again. This repeats indefinitely while chip select stays low.
- R5: The compare and density fields are captured on the falling edge that starts each repetition. Changes to them during a byte appear only in the next repetition.
- R6: While bit 7 is being presented, `so_data` follows the live ready state (the inverse of `busy`) with no SCK edge required.
- R7: After any command other than 0x57, the output stays disabled until chip select goes high. The next selection accepts a new command.
- R8: Raising chip select at any point ends the readout. The next selection starts over with command collection.
- R9: Apart from the live bit 7, `so_data` changes only on SCK falling edges and holds across rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock, faster than SCK |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock (mode 0 or 3) |
| si | input | 1 | Serial command input |
| busy | input | 1 | Live busy flag from the sequencer |
| cmp_result | input | 1 | Compare result bit |
| density | input | 3 | Density code |
| so_data | output | 1 | Serial status output |
| so_oe | output | 1 | Output enable; 0 means high impedance |

## Verification
The checker assumes each SCK phase lasts at least two model clocks, so every SCK edge is seen as a separate pulse. It also assumes SCK is low when reset is released. The bench holds each SCK level for four model clocks. It changes chip select only while SCK is low, and it changes `cmp_result` and `density` only between SCK edges. With these rules, the index-step, wrap and hold-on-rise properties see exactly one fall or rise per SCK transition.

// File: rtl/statrd_pkg.sv
package statrd_pkg;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(BYTE_W);
    localparam int DENS_W  = 3;
    localparam int RSV_W   = BYTE_W - 2 - DENS_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ARMED,
        ST_STREAM,
        ST_IGNORE
    } statrd_state_t;
endpackage

// File: rtl/sck_edge_detect.sv
module sck_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/opcode_shifter.sv
module opcode_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_next,
    output logic         last
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     word_q;
    logic [CNT_W-1:0] cnt_q;

    assign word_next = {word_q[W-2:0], din};
    assign last      = (cnt_q == CNT_W'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en && cnt_q != CNT_W'(W)) begin
            word_q <= word_next;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/status_serializer.sv
module status_serializer
    import statrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              ready_live,
    input  logic              cmp,
    input  logic [DENS_W-1:0] dens,
    output logic              so_bit,
    output logic [IDX_W-1:0]  idx
);
    logic [DENS_W:0]   snap_q;
    logic [BYTE_W-1:0] frame;

    assign frame = {1'b0, snap_q, {RSV_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            idx    <= IDX_W'(BYTE_W - 1);
        end else if (load) begin
            snap_q <= {cmp, dens};
            idx    <= IDX_W'(BYTE_W - 1);
        end else if (step) begin
            idx    <= idx - IDX_W'(1);
        end
    end

    always_comb begin
        if (idx == IDX_W'(BYTE_W - 1)) so_bit = ready_live;
        else                           so_bit = frame[idx];
    end
endmodule

// File: rtl/status_readout.sv
module status_readout
    import statrd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] READ_OPCODE = 8'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              busy,
    input  logic              cmp_result,
    input  logic [DENS_W-1:0] density,
    output logic              so_data,
    output logic              so_oe
);
    statrd_state_t state_q, state_d;

    logic             sck_rise, sck_fall;
    logic [BYTE_W-1:0] op_word;
    logic             op_last, op_clear, op_shift;
    logic             ser_load, ser_step, ser_bit;
    logic [IDX_W-1:0] bit_idx;

    sck_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    opcode_shifter #(.W(BYTE_W)) u_op (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (op_clear),
        .shift_en  (op_shift),
        .din       (si),
        .word_next (op_word),
        .last      (op_last)
    );

    status_serializer u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ser_load),
        .step       (ser_step),
        .ready_live (~busy),
        .cmp        (cmp_result),
        .dens       (density),
        .so_bit     (ser_bit),
        .idx        (bit_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (sck_rise && op_last)
                               state_d = (op_word == READ_OPCODE) ? ST_ARMED : ST_IGNORE;
                ST_ARMED:  if (sck_fall) state_d = ST_STREAM;
                ST_STREAM: state_d = ST_STREAM;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        op_clear = (state_q == ST_IDLE);
        op_shift = (state_q == ST_OPCODE) && sck_rise && !cs_n;
        ser_load = !cs_n && sck_fall &&
                   ((state_q == ST_ARMED) ||
                    ((state_q == ST_STREAM) && bit_idx == '0));
        ser_step = !cs_n && sck_fall && (state_q == ST_STREAM) && bit_idx != '0;
        so_oe    = (state_q == ST_STREAM);
        so_data  = so_oe ? ser_bit : 1'b0;
    end
endmodule

// File: rtl/status_readout_chk.sv
module status_readout_chk
    import statrd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sck,
    input logic             so_data,
    input logic             so_oe,
    input logic [IDX_W-1:0] idx
);
    assert_hiz_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && idx < IDX_W'(RSV_W)) |-> !so_data);

    assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !cs_n && $fell(sck) && idx != '0) |=> idx == $past(idx) - IDX_W'(1));

    assert_byte_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !cs_n && $fell(sck) && idx == '0) |=> idx == IDX_W'(BYTE_W - 1));

    assert_hold_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && $rose(sck) && idx != IDX_W'(BYTE_W - 1)) |-> $stable(so_data));
endmodule

bind status_readout status_readout_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sck     (sck),
    .so_data (so_data),
    .so_oe   (so_oe),
    .idx     (bit_idx)
);

// File: tb/status_readout_test.sv
module status_readout_test;
    logic       clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
    logic       busy = 0, cmp = 0;
    logic [2:0] dens = 0;
    logic       so_data, so_oe;
    int         total = 0, bad = 0;
    bit         finished = 0;
    logic [7:0] b;

    // each entry: {busy, compare, density[2:0]}
    localparam logic [4:0] VEC [6] = '{5'b0_0_000, 5'b1_1_111, 5'b0_1_010,
                                       5'b1_0_101, 5'b0_0_111, 5'b1_1_001};

    always #4 clk = ~clk;

    status_readout uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .busy(busy), .cmp_result(cmp), .density(dens),
        .so_data(so_data), .so_oe(so_oe)
    );

    function automatic logic [7:0] expect_byte(input logic [4:0] v);
        return {~v[4], v[3], v[2:0], 3'b000};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] v);
        busy = v[4]; cmp = v[3]; dens = v[2:0];
    endtask

    task automatic sck_up();
        @(negedge clk) sck = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic sck_dn();
        @(negedge clk) sck = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic select();
        @(negedge clk) cs_n = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic deselect();
        @(negedge clk) cs_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_op(input logic [7:0] op, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            si = op[7-i];
            sck_up();
            sck_dn();
        end
    endtask

    // samples bits 7..0; the final fall is left to the caller
    task automatic read_byte(output logic [7:0] r, input int flip_after, input logic [4:0] fv);
        for (int i = 7; i >= 0; i--) begin
            r[i] = so_data;
            sck_up();
            if (i != 0) begin
                sck_dn();
                if (i == flip_after) apply(fv);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("R1 reset oe", {7'b0, so_oe}, 8'h00);
        check("R1 reset data", {7'b0, so_data}, 8'h00);

        // table walk: two repetitions per read, fields changed between them
        for (int k = 0; k < 6; k++) begin
            apply(VEC[k]);
            select();
            send_op(8'h57, 8);
            check("R2 oe after opcode", {7'b0, so_oe}, 8'h01);
            read_byte(b, -1, 5'b0);
            check("R3 first byte", b, expect_byte(VEC[k]));
            apply(VEC[(k + 1) % 6]);
            sck_dn();
            read_byte(b, -1, 5'b0);
            check("R4 R5 repeated byte", b, expect_byte(VEC[(k + 1) % 6]));
            sck_dn();
            deselect();
            check("R8 oe after deselect", {7'b0, so_oe}, 8'h00);
        end

        // R2: seven bits only must not start
        select();
        send_op(8'h57, 7);
        check("R2 partial opcode", {7'b0, so_oe}, 8'h00);
        deselect();

        // R5: change mid-byte only shows next repetition
        apply(5'b0_0_101);
        select();
        send_op(8'h57, 8);
        read_byte(b, 6, 5'b0_1_010);
        check("R5 mid-byte change held", b, expect_byte(5'b0_0_101));
        sck_dn();
        read_byte(b, -1, 5'b0);
        check("R5 change in next rep", b, expect_byte(5'b0_1_010));
        sck_dn();
        deselect();

        // R6: poll bit 7 with SCK stopped
        apply(5'b1_0_000);
        select();
        send_op(8'h57, 8);
        check("R6 busy shows 0", {7'b0, so_data}, 8'h00);
        repeat (10) @(negedge clk);
        busy = 0;
        #1;
        check("R6 ready rises live", {7'b0, so_data}, 8'h01);
        deselect();

        // R7: other command ignored, next selection works
        select();
        send_op(8'h58, 8);
        sck_up(); sck_dn();
        check("R7 other opcode oe", {7'b0, so_oe}, 8'h00);
        deselect();
        apply(5'b0_1_110);
        select();
        send_op(8'h57, 8);
        read_byte(b, -1, 5'b0);
        check("R7 read after ignore", b, expect_byte(5'b0_1_110));
        sck_dn();
        deselect();

        // R8: abort mid-byte then restart
        select();
        send_op(8'h57, 8);
        sck_up(); sck_dn();
        deselect();
        check("R8 abort oe", {7'b0, so_oe}, 8'h00);
        check("R1 data while deselected", {7'b0, so_data}, 8'h00);
        apply(5'b1_1_011);
        select();
        send_op(8'h57, 8);
        read_byte(b, -1, 5'b0);
        check("R8 restart byte", b, expect_byte(5'b1_1_011));
        sck_dn();
        deselect();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule